// File: doc/BRIEF.md
# Masked Request Match and Statistics Action Unit

This unit watches request packets that have already been granted by an upstream arbiter. On any cycle where such a packet is presented with its valid strobe, the packet is tested against four programmable descriptors. Each descriptor has a 53-bit mask and a 53-bit compare value. A descriptor matches when the packet ANDed with its mask equals its compare value.

The four match bits feed four actions: reloading a statistics counter, decrementing it, pulsing an interrupt request to the system-management logic, and pulsing an error/trap source. Each action has its own per-descriptor enable mask. For each action, the masked matches are ORed into a single trigger.

Software programs the descriptors, the action enables and the counter reload value through a single-cycle register write port. All of this storage can be read back through a combinational read port. Register bits with no function read as zero and ignore writes.

Top module: `pkt_match_stats`

## Requirements
- R1: After reset, every compare value and every mask register reads 0x001FFFFF_FFFFFFFF. The action-enable register, the reload register and the counter read zero, and neither pulse output is high.
- R2: Register addresses are as follows: value of descriptor i at i (0..3), mask of descriptor i at 4+i, action enables at 8, reload at 9. Unmapped addresses read zero. Reserved bits read zero and writes to them are ignored: value/mask bits 63:53, action bits 63:16, reload bits 63:16.
- R3: Descriptor i matches a packet when (packet AND mask_i) equals value_i over bits 52:0.
- R4: With the valid strobe low, no match has any effect: the counter holds and both pulses stay low.
- R5: Action-enable bits [3:0] are the reload enables, one per descriptor, bit i for descriptor i. A valid packet that matches an enabled descriptor loads the reload value into the counter at the next clock edge.
- R6: Action-enable bits [7:4] are the decrement enables. A valid packet that matches an enabled descriptor decrements the counter by one at the next edge. At zero, the counter stays at zero.
- R7: When a reload and a decrement trigger in the same cycle, the reload wins.
- R8: Action-enable bits [11:8] are the interrupt enables. A valid packet that matches an enabled descriptor makes the interrupt output high for exactly the one cycle after the edge that samples the packet.
- R9: Action-enable bits [15:12] enable the error/trap source per descriptor. The error pulse follows the same one-cycle timing as the interrupt, and never fires for a descriptor whose enable bit is clear.
- R10: Per action, the masked matches are ORed. A match on any enabled descriptor triggers the action, and a match on a descriptor that is disabled for that action has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 64 | Combinational register read data |
| pkt_valid | input | 1 | An arbitrated packet is present this cycle |
| pkt_data | input | 53 | Arbitrated request packet |
| cnt_value | output | 16 | Statistics counter |
| irq_pulse | output | 1 | One-cycle system-management interrupt request |
| err_pulse | output | 1 | One-cycle error/trap pulse |

## Verification
The bench keeps four descriptors and the full 53-bit packet inside a 64-bit register. This puts the reserved upper bits and the exact reset pattern within reach of checks. The counter is 16 bits wide. A reload value of one lets two decrements cover the saturating floor in a few packets. The two descriptors left at their reset pattern match only an all-ones packet. That packet therefore exercises the OR of several enabled descriptors, and the effect of clearing one enable, in the same run.

// File: rtl/pms_pkg.sv
package pms_pkg;
  // Order of action fields in the action-enable register.
  typedef enum int {
    ACT_LOAD = 0,
    ACT_DEC  = 1,
    ACT_IRQ  = 2,
    ACT_ERR  = 3
  } act_e;

  localparam int NUM_ACT = 4;
endpackage

// File: rtl/pms_desc_bank.sv
module pms_desc_bank #(
  parameter int NUM_DESC = 4,
  parameter int PKT_W    = 53
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_DESC-1:0]                wr_val_sel,
  input  logic [NUM_DESC-1:0]                wr_msk_sel,
  input  logic [PKT_W-1:0]                   wr_field,
  input  logic [PKT_W-1:0]                   pkt_data,
  output logic [NUM_DESC-1:0][PKT_W-1:0]     val_q,
  output logic [NUM_DESC-1:0][PKT_W-1:0]     msk_q,
  output logic [NUM_DESC-1:0]                hit_vec
);
  localparam logic [PKT_W-1:0] RST_PAT = {PKT_W{1'b1}};

  function automatic logic masked_hit(input logic [PKT_W-1:0] pkt,
                                      input logic [PKT_W-1:0] msk,
                                      input logic [PKT_W-1:0] val);
    return (pkt & msk) == val;
  endfunction

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[d] <= RST_PAT;
        msk_q[d] <= RST_PAT;
      end else begin
        if (wr_val_sel[d]) val_q[d] <= wr_field;
        if (wr_msk_sel[d]) msk_q[d] <= wr_field;
      end
    end

    assign hit_vec[d] = masked_hit(pkt_data, msk_q[d], val_q[d]);
  end
endmodule

// File: rtl/pms_ctrl_regs.sv
module pms_ctrl_regs #(
  parameter int NUM_DESC = 4,
  parameter int PKT_W    = 53,
  parameter int REG_W    = 64,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 4,
  parameter int ACT_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [ACT_W-1:0]               wr_act,
  input  logic [CNT_W-1:0]               wr_cnt,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic [NUM_DESC-1:0][PKT_W-1:0] val_q,
  input  logic [NUM_DESC-1:0][PKT_W-1:0] msk_q,
  output logic [ACT_W-1:0]               act_q,
  output logic [CNT_W-1:0]               reload_q,
  output logic [REG_W-1:0]               rd_data
);
  localparam int ACT_ADDR = 2 * NUM_DESC;
  localparam int RLD_ADDR = 2 * NUM_DESC + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ACT_ADDR)) act_q    <= wr_act;
      if (wr_addr == ADDR_W'(RLD_ADDR)) reload_q <= wr_cnt;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int d = 0; d < NUM_DESC; d++) begin
      if (rd_addr == ADDR_W'(d))            rd_data = REG_W'(val_q[d]);
      if (rd_addr == ADDR_W'(NUM_DESC + d)) rd_data = REG_W'(msk_q[d]);
    end
    if (rd_addr == ADDR_W'(ACT_ADDR)) rd_data = REG_W'(act_q);
    if (rd_addr == ADDR_W'(RLD_ADDR)) rd_data = REG_W'(reload_q);
  end
endmodule

// File: rtl/pms_action_unit.sv
module pms_action_unit #(
  parameter int NUM_DESC = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_valid,
  input  logic [NUM_DESC-1:0] hit_vec,
  input  logic [NUM_DESC-1:0] en_load,
  input  logic [NUM_DESC-1:0] en_dec,
  input  logic [NUM_DESC-1:0] en_irq,
  input  logic [NUM_DESC-1:0] en_err,
  input  logic [CNT_W-1:0]    reload_q,
  output logic                load_trig,
  output logic                dec_trig,
  output logic                irq_trig,
  output logic                err_trig,
  output logic [CNT_W-1:0]    cnt_q,
  output logic                irq_pulse,
  output logic                err_pulse
);
  function automatic logic any_enabled(input logic [NUM_DESC-1:0] hits,
                                       input logic [NUM_DESC-1:0] en);
    return |(hits & en);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rld,
                                                  input logic             ld,
                                                  input logic             dc);
    if (ld) return rld;
    if (dc) return (cur == '0) ? '0 : cur - 1'b1;
    return cur;
  endfunction

  assign load_trig = pkt_valid && any_enabled(hit_vec, en_load);
  assign dec_trig  = pkt_valid && any_enabled(hit_vec, en_dec);
  assign irq_trig  = pkt_valid && any_enabled(hit_vec, en_irq);
  assign err_trig  = pkt_valid && any_enabled(hit_vec, en_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      irq_pulse <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      cnt_q     <= next_count(cnt_q, reload_q, load_trig, dec_trig);
      irq_pulse <= irq_trig;
      err_pulse <= err_trig;
    end
  end
endmodule

// File: rtl/pkt_match_stats.sv
module pkt_match_stats #(
  parameter int NUM_DESC = 4,
  parameter int PKT_W    = 53,
  parameter int REG_W    = 64,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = $clog2(2 * NUM_DESC + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              pkt_valid,
  input  logic [PKT_W-1:0]  pkt_data,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              irq_pulse,
  output logic              err_pulse
);
  import pms_pkg::*;

  localparam int ACT_W = NUM_ACT * NUM_DESC;

  logic [NUM_DESC-1:0]                wr_val_sel, wr_msk_sel;
  logic [NUM_DESC-1:0][PKT_W-1:0]     val_q, msk_q;
  logic [NUM_DESC-1:0]                hit_vec;
  logic [ACT_W-1:0]                   act_q;
  logic [CNT_W-1:0]                   reload_q;
  logic                               load_trig, dec_trig, irq_trig, err_trig;
  logic                               unused_rsvd;

  // Reserved write bits above the widest field are dropped.
  assign unused_rsvd = ^wr_data[REG_W-1:PKT_W];

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_sel
    assign wr_val_sel[d] = wr_en && (wr_addr == ADDR_W'(d));
    assign wr_msk_sel[d] = wr_en && (wr_addr == ADDR_W'(NUM_DESC + d));
  end

  pms_desc_bank #(.NUM_DESC(NUM_DESC), .PKT_W(PKT_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_val_sel (wr_val_sel),
    .wr_msk_sel (wr_msk_sel),
    .wr_field   (wr_data[PKT_W-1:0]),
    .pkt_data   (pkt_data),
    .val_q      (val_q),
    .msk_q      (msk_q),
    .hit_vec    (hit_vec)
  );

  pms_ctrl_regs #(
    .NUM_DESC(NUM_DESC), .PKT_W(PKT_W), .REG_W(REG_W),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .ACT_W(ACT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_act   (wr_data[ACT_W-1:0]),
    .wr_cnt   (wr_data[CNT_W-1:0]),
    .rd_addr  (rd_addr),
    .val_q    (val_q),
    .msk_q    (msk_q),
    .act_q    (act_q),
    .reload_q (reload_q),
    .rd_data  (rd_data)
  );

  pms_action_unit #(.NUM_DESC(NUM_DESC), .CNT_W(CNT_W)) u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_valid (pkt_valid),
    .hit_vec   (hit_vec),
    .en_load   (act_q[int'(ACT_LOAD)*NUM_DESC +: NUM_DESC]),
    .en_dec    (act_q[int'(ACT_DEC)*NUM_DESC +: NUM_DESC]),
    .en_irq    (act_q[int'(ACT_IRQ)*NUM_DESC +: NUM_DESC]),
    .en_err    (act_q[int'(ACT_ERR)*NUM_DESC +: NUM_DESC]),
    .reload_q  (reload_q),
    .load_trig (load_trig),
    .dec_trig  (dec_trig),
    .irq_trig  (irq_trig),
    .err_trig  (err_trig),
    .cnt_q     (cnt_value),
    .irq_pulse (irq_pulse),
    .err_pulse (err_pulse)
  );
endmodule

// File: rtl/pms_chk.sv
module pms_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             load_trig,
  input logic             dec_trig,
  input logic             irq_trig,
  input logic             err_trig,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] cnt_value,
  input logic             irq_pulse,
  input logic             err_pulse
);
  // R4
  idle_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (!irq_pulse && !err_pulse && $stable(cnt_value)));

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_trig |=> cnt_value == $past(reload_q));

  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_trig && !load_trig && cnt_value != '0) |=>
      cnt_value == CNT_W'($past(cnt_value) - 1'b1));

  // R6
  dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_trig && !load_trig && cnt_value == '0) |=> cnt_value == '0);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(irq_trig));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_trig |=> irq_pulse);

  // R9
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(err_trig));
endmodule

bind pkt_match_stats pms_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .load_trig (load_trig),
  .dec_trig  (dec_trig),
  .irq_trig  (irq_trig),
  .err_trig  (err_trig),
  .reload_q  (reload_q),
  .cnt_value (cnt_value),
  .irq_pulse (irq_pulse),
  .err_pulse (err_pulse)
);

// File: tb/pkt_match_stats_test.sv
`timescale 1ns/1ps
module pkt_match_stats_test;
  localparam int ND = 4;
  localparam int PW = 53;
  localparam int RW = 64;
  localparam int CW = 16;
  localparam int AW = 4;

  typedef struct {
    logic          irq;
    logic          err;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [RW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [RW-1:0] rd_data;
  logic          pkt_valid = 1'b0;
  logic [PW-1:0] pkt_data = '0;
  logic [CW-1:0] cnt_value;
  logic          irq_pulse, err_pulse;

  int errors = 0;
  int checks = 0;
  exp_t q[$];

  logic [PW-1:0] m_val [ND];
  logic [PW-1:0] m_msk [ND];
  logic [15:0]   m_act;
  logic [CW-1:0] m_rld;
  logic [CW-1:0] m_cnt;

  always #2 clk = ~clk;

  pkt_match_stats #(.NUM_DESC(ND), .PKT_W(PW), .REG_W(RW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .cnt_value(cnt_value),
    .irq_pulse(irq_pulse), .err_pulse(err_pulse)
  );

  task automatic check(string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(int a, logic [RW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < ND) m_val[a] = d[PW-1:0];
    else if (a < 2*ND) m_msk[a-ND] = d[PW-1:0];
    else if (a == 2*ND) m_act = d[15:0];
    else if (a == 2*ND+1) m_rld = d[CW-1:0];
  endtask

  task automatic reg_read(string tag, int a, logic [RW-1:0] exp);
    rd_addr = AW'(a);
    #1;
    check(tag, rd_data, exp);
  endtask

  // Driver: presents one cycle of packet input and queues the expected outcome.
  task automatic send(logic v, logic [PW-1:0] d, string tag);
    logic [ND-1:0] h;
    logic ld, dc, ir, er;
    exp_t e;
    @(negedge clk);
    pkt_valid = v; pkt_data = d;
    for (int i = 0; i < ND; i++) h[i] = ((d & m_msk[i]) == m_val[i]);
    ld = 1'b0; dc = 1'b0; ir = 1'b0; er = 1'b0;
    for (int i = 0; i < ND; i++) begin
      ld |= v & h[i] & m_act[i];
      dc |= v & h[i] & m_act[4+i];
      ir |= v & h[i] & m_act[8+i];
      er |= v & h[i] & m_act[12+i];
    end
    if (ld) m_cnt = m_rld;
    else if (dc && m_cnt != 0) m_cnt = m_cnt - 1'b1;
    e.irq = ir; e.err = er; e.cnt = m_cnt; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares the registered outputs just after the sampling edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " outputs"}, {45'd0, e.irq, e.err, e.cnt},
              {45'd0, irq_pulse, err_pulse, cnt_value});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [RW-1:0] RST_READ = 64'h001F_FFFF_FFFF_FFFF;
  localparam logic [PW-1:0] ALL1     = {PW{1'b1}};

  initial begin
    for (int i = 0; i < ND; i++) begin
      m_val[i] = ALL1; m_msk[i] = ALL1;
    end
    m_act = '0; m_rld = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int i = 0; i < 2*ND; i++) reg_read("R1 desc reg", i, RST_READ);
    reg_read("R1 action reg", 2*ND, '0);
    reg_read("R1 reload reg", 2*ND+1, '0);
    check("R1 counter/pulses", {cnt_value, irq_pulse, err_pulse}, '0);

    // R2: reserved bits and unmapped address
    reg_write(0, 64'hFFE0_0000_0000_0000);
    reg_read("R2 value reserved ignored", 0, '0);
    reg_write(2*ND, '1);
    reg_read("R2 action width", 2*ND, 64'h0000_0000_0000_FFFF);
    reg_write(2*ND+1, 64'hABCD_0000_0000_1234);
    reg_read("R2 reload width", 2*ND+1, 64'h1234);
    reg_read("R2 unmapped", 15, '0);

    // Program descriptors: d0 low byte 0x12, d1 bit 8 set; d2/d3 left at reset.
    reg_write(0, 64'h12);
    reg_write(ND+0, 64'hFF);
    reg_write(1, 64'h100);
    reg_write(ND+1, 64'h100);
    reg_read("R2 mask readback", ND+1, 64'h100);
    // load:d0, dec:d1, irq:d0|d2, err:d3
    reg_write(2*ND, 64'h8521);
    reg_write(2*ND+1, 64'd5);

    send(1'b1, 53'h12,  "R5 R8 load+irq");
    send(1'b0, 53'h12,  "R4 idle ignored");
    send(1'b1, 53'h100, "R6 R10 dec only");
    send(1'b1, 53'h112, "R7 load beats dec");
    send(1'b1, 53'h13,  "R3 no match");
    send(1'b1, 53'hA12, "R3 masked bits ignored");
    send(1'b0, 53'h0,   "R4 idle");
    reg_write(2*ND+1, 64'd1);
    send(1'b1, 53'h12,  "R5 reload one");
    send(1'b1, 53'h100, "R6 dec to zero");
    send(1'b1, 53'h100, "R6 saturate at zero");
    send(1'b1, ALL1,    "R9 R10 all-ones multi hit");
    send(1'b0, ALL1,    "R4 idle all-ones");
    reg_write(2*ND, 64'h0521);
    send(1'b1, ALL1,    "R9 err disabled");
    reg_write(2*ND, 64'h0020);
    send(1'b1, 53'h12,  "R10 disabled desc no irq/load");
    send(1'b0, 53'h0,   "R4 final idle");
    repeat (3) @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule